// File: doc/BRIEF.md
# Duplicate-Tag Snoop Control Unit

This unit sits between a small cluster of cores and the next memory level. Each core has a private, direct-mapped L1 data cache that uses MESI states. For every core that takes part in coherence, the unit holds a shadow copy of that core's L1 tag and state array. When a core misses, the unit checks the shadow copies of the other cores first. If a peer holds the line, the unit has that peer hand it over directly. If no peer holds it, the unit sends one request downstream. The unit never broadcasts snoops: only the caches that actually hold the line receive a command.

Cores send four kinds of request on their own channel: read miss, write miss, upgrade and eviction. Simultaneous requests are served in round-robin order, with one lookup per cycle. Each granted request produces a one-cycle response to the requester one clock after the grant. In the same cycle the unit drives any snoop command to the holders and any peer-transfer command. A miss that goes downstream holds the unit busy until memory signals the fill. The response to the requester follows one clock after the fill.

Top module: `snoop_ctl_unit`

## Requirements
- R1: The shadow tags follow every fill, eviction and state change. After a core evicts a line (request code 3), a later miss by another core on that line goes downstream, provided no other core holds the line.
- R2: A read miss (code 0) or write miss (code 1) that hits a peer's shadow entry raises no downstream request.
- R3: A read miss served by a clean peer (state S=1 or E=2) produces a copy transfer (move flag 0). The unit sends a downgrade snoop (invalidate flag 0) to every holder, and the requester receives state S=1 with the peer flag set.
- R4: A miss served by a dirty peer (state M=3) produces a move transfer (move flag 1) and invalidates the source. The requester receives state M=3 with the peer flag set.
- R5: A miss that no participating peer holds is forwarded downstream exactly once, with the line address. One clock after the fill, the requester receives E=2 for a read miss or M=3 for a write miss.
- R6: An upgrade (code 2) invalidates every other participating holder. The upgrade is acknowledged with state M=3. An upgrade from E raises no snoop at all.
- R7: Cores whose participate bit is 0 are never looked up or snooped. Their misses go straight downstream, and no peer's state changes.
- R8: At most one request is granted per cycle, and only to a requesting core. Grants rotate round-robin starting after the last granted core.
- R9: A write miss that hits only clean peers copies the line from a holder (move flag 0) and invalidates all holders. The requester receives M=3.
- R10: After reset every output is low, and every shadow entry is invalid.
- R11: When several peers hold the line, the transfer source is the lowest-numbered holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| participate_i | input | N_CORES | Static per-core coherence participation |
| req_valid_i | input | N_CORES | Per-core request valid |
| req_type_i | input | 2*N_CORES | Per-core request code: 0 read miss, 1 write miss, 2 upgrade, 3 evict |
| req_addr_i | input | ADDR_W*N_CORES | Per-core line address {tag, index} |
| req_ready_o | output | N_CORES | Grant, one-hot, combinational |
| rsp_valid_o | output | N_CORES | One-cycle response to a core |
| rsp_state_o | output | 2 | Granted state: 0 I, 1 S, 2 E, 3 M |
| rsp_peer_o | output | 1 | Response data comes from a peer |
| snp_valid_o | output | N_CORES | Snoop command to each holder |
| snp_inv_o | output | 1 | 1 invalidate, 0 downgrade to S |
| snp_addr_o | output | ADDR_W | Line address of the current command |
| xfer_valid_o | output | 1 | Peer-to-peer transfer command |
| xfer_move_o | output | 1 | 1 move dirty line, 0 clean copy |
| xfer_src_o | output | CID_W | Source core |
| xfer_dst_o | output | CID_W | Destination core |
| xfer_addr_o | output | ADDR_W | Line address of the transfer |
| mem_req_valid_o | output | 1 | Downstream line request, one cycle |
| mem_req_addr_o | output | ADDR_W | Downstream line address |
| mem_fill_valid_i | input | 1 | Downstream fill complete |

## Verification
A shadow entry that has drifted from the real tags shows up at the ports on the very next miss to that line. A stale holder shows as a transfer or snoop where a downstream request was expected. A lost holder shows as a spurious memory request, or as an E grant where S was due. The directed sequence therefore walks a single line through every MESI holder pattern, and each step exposes the shadow state left by the step before in the responses one clock after the grant. Arbitration faults show within the cycle of the grant as a non-rotating or multi-hot ready vector.

// File: rtl/scu_pkg.sv
package scu_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_UPG = 2'd2, RQ_EVICT = 2'd3} req_e;
endpackage

// File: rtl/scu_rr_arb.sv
module scu_rr_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_id_o,
  output logic          any_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int idx;
    gnt_o    = '0;
    gnt_id_o = '0;
    any_o    = 1'b0;
    for (int off = 0; off < N; off++) begin
      idx = int'(ptr_q) + off;
      if (idx >= N) idx = idx - N;
      if (en_i && !any_o && req_i[idx]) begin
        any_o      = 1'b1;
        gnt_o[idx] = 1'b1;
        gnt_id_o   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (any_o) ptr_q <= (gnt_id_o == IW'(N - 1)) ? '0 : gnt_id_o + 1'b1;
  end
endmodule

// File: rtl/scu_dup_tags.sv
module scu_dup_tags
  import scu_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  parameter int SETS  = 1 << IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [N-1:0][TAG_W-1:0]   rd_tag_o,
  output mesi_e [N-1:0]             rd_state_o,
  input  logic [N-1:0]              wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [TAG_W-1:0]          wr_tag_i,
  input  mesi_e [N-1:0]             wr_state_i
);
  for (genvar c = 0; c < N; c++) begin : g_core
    logic [TAG_W-1:0] tag_q [SETS];
    mesi_e            st_q  [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) begin
          tag_q[s] <= '0;
          st_q[s]  <= ST_I;
        end
      end else if (wr_en_i[c]) begin
        tag_q[wr_idx_i] <= wr_tag_i;
        st_q[wr_idx_i]  <= wr_state_i[c];
      end
    end

    assign rd_tag_o[c]   = tag_q[rd_idx_i];
    assign rd_state_o[c] = st_q[rd_idx_i];
  end
endmodule

// File: rtl/scu_lookup.sv
module scu_lookup
  import scu_pkg::*;
#(
  parameter int N     = 4,
  parameter int TAG_W = 8,
  parameter int IW    = $clog2(N)
) (
  input  logic                    en_i,
  input  logic [IW-1:0]           self_i,
  input  logic [N-1:0]            part_i,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [N-1:0][TAG_W-1:0] rd_tag_i,
  input  mesi_e [N-1:0]           rd_state_i,
  output logic [N-1:0]            hit_o,
  output logic                    dirty_o,
  output logic                    any_o,
  output logic [IW-1:0]           src_o
);
  always_comb begin
    hit_o   = '0;
    dirty_o = 1'b0;
    src_o   = '0;
    for (int c = 0; c < N; c++) begin
      if (en_i && part_i[c] && (IW'(c) != self_i) &&
          (rd_state_i[c] != ST_I) && (rd_tag_i[c] == tag_i))
        hit_o[c] = 1'b1;
    end
    // descending scan: lowest holder wins
    for (int c = N - 1; c >= 0; c--) begin
      if (hit_o[c]) begin
        src_o = IW'(c);
        if (rd_state_i[c] == ST_M) dirty_o = 1'b1;
      end
    end
    any_o = |hit_o;
  end
endmodule

// File: rtl/snoop_ctl_unit.sv
module snoop_ctl_unit
  import scu_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 4,
  parameter int CID_W   = $clog2(N_CORES),
  parameter int TAG_W   = ADDR_W - IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CORES-1:0]          participate_i,
  input  logic [N_CORES-1:0]          req_valid_i,
  input  logic [2*N_CORES-1:0]        req_type_i,
  input  logic [ADDR_W*N_CORES-1:0]   req_addr_i,
  output logic [N_CORES-1:0]          req_ready_o,
  output logic [N_CORES-1:0]          rsp_valid_o,
  output logic [1:0]                  rsp_state_o,
  output logic                        rsp_peer_o,
  output logic [N_CORES-1:0]          snp_valid_o,
  output logic                        snp_inv_o,
  output logic [ADDR_W-1:0]           snp_addr_o,
  output logic                        xfer_valid_o,
  output logic                        xfer_move_o,
  output logic [CID_W-1:0]            xfer_src_o,
  output logic [CID_W-1:0]            xfer_dst_o,
  output logic [ADDR_W-1:0]           xfer_addr_o,
  output logic                        mem_req_valid_o,
  output logic [ADDR_W-1:0]           mem_req_addr_o,
  input  logic                        mem_fill_valid_i
);
  // arbitration
  logic [N_CORES-1:0] gnt;
  logic [CID_W-1:0]   g_id;
  logic               any_gnt;
  logic               busy_q, busy_d;

  scu_rr_arb #(.N(N_CORES), .IW(CID_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!busy_q),
    .req_i    (req_valid_i),
    .gnt_o    (gnt),
    .gnt_id_o (g_id),
    .any_o    (any_gnt)
  );
  assign req_ready_o = gnt;

  req_e               sel_type;
  logic [ADDR_W-1:0]  sel_addr;
  assign sel_type = req_e'(req_type_i[int'(g_id)*2 +: 2]);
  assign sel_addr = req_addr_i[int'(g_id)*ADDR_W +: ADDR_W];

  // pending downstream miss
  logic [CID_W-1:0]  pend_core_q, pend_core_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic              pend_wr_q, pend_wr_d;

  logic [CID_W-1:0]  lk_core;
  logic [ADDR_W-1:0] lk_addr;
  logic              self_part;
  assign lk_core   = busy_q ? pend_core_q : g_id;
  assign lk_addr   = busy_q ? pend_addr_q : sel_addr;
  assign self_part = participate_i[lk_core];

  // shadow tag store
  logic [N_CORES-1:0][TAG_W-1:0] rd_tag;
  mesi_e [N_CORES-1:0]           rd_state;
  logic [N_CORES-1:0]            wr_en;
  mesi_e [N_CORES-1:0]           wr_state;

  scu_dup_tags #(.N(N_CORES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lk_addr[IDX_W-1:0]),
    .rd_tag_o   (rd_tag),
    .rd_state_o (rd_state),
    .wr_en_i    (wr_en),
    .wr_idx_i   (lk_addr[IDX_W-1:0]),
    .wr_tag_i   (lk_addr[ADDR_W-1:IDX_W]),
    .wr_state_i (wr_state)
  );

  logic [N_CORES-1:0] hit;
  logic               dirty, any_hit;
  logic [CID_W-1:0]   src_id;

  scu_lookup #(.N(N_CORES), .TAG_W(TAG_W), .IW(CID_W)) u_lookup (
    .en_i       (self_part),
    .self_i     (lk_core),
    .part_i     (participate_i),
    .tag_i      (lk_addr[ADDR_W-1:IDX_W]),
    .rd_tag_i   (rd_tag),
    .rd_state_i (rd_state),
    .hit_o      (hit),
    .dirty_o    (dirty),
    .any_o      (any_hit),
    .src_o      (src_id)
  );

  // decision
  logic [N_CORES-1:0] rsp_v_d, snp_v_d;
  mesi_e              rsp_st_d, new_st;
  logic               rsp_peer_d, snp_inv_d, xfer_v_d, xfer_mv_d, mem_v_d;
  logic               inv_holders;

  always_comb begin
    busy_d      = busy_q;
    pend_core_d = pend_core_q;
    pend_addr_d = pend_addr_q;
    pend_wr_d   = pend_wr_q;
    wr_en       = '0;
    for (int c = 0; c < N_CORES; c++) wr_state[c] = ST_I;
    rsp_v_d     = '0;
    rsp_st_d    = ST_I;
    rsp_peer_d  = 1'b0;
    snp_v_d     = '0;
    snp_inv_d   = 1'b0;
    xfer_v_d    = 1'b0;
    xfer_mv_d   = 1'b0;
    mem_v_d     = 1'b0;
    new_st      = ST_I;
    inv_holders = 1'b0;

    if (busy_q) begin
      if (mem_fill_valid_i) begin
        busy_d      = 1'b0;
        inv_holders = pend_wr_q;
        new_st      = pend_wr_q ? ST_M : (any_hit ? ST_S : ST_E);
        snp_v_d     = hit;
        snp_inv_d   = inv_holders;
        for (int c = 0; c < N_CORES; c++)
          if (hit[c]) begin
            wr_en[c]    = 1'b1;
            wr_state[c] = inv_holders ? ST_I : ST_S;
          end
        if (self_part) begin
          wr_en[lk_core]    = 1'b1;
          wr_state[lk_core] = new_st;
        end
        rsp_v_d[lk_core] = 1'b1;
        rsp_st_d         = new_st;
      end
    end else if (any_gnt) begin
      unique case (sel_type)
        RQ_RD, RQ_WR: begin
          if (any_hit) begin
            inv_holders = (sel_type == RQ_WR) || dirty;
            new_st      = inv_holders ? ST_M : ST_S;
            xfer_v_d    = 1'b1;
            xfer_mv_d   = dirty;
            snp_v_d     = hit;
            snp_inv_d   = inv_holders;
            for (int c = 0; c < N_CORES; c++)
              if (hit[c]) begin
                wr_en[c]    = 1'b1;
                wr_state[c] = inv_holders ? ST_I : ST_S;
              end
            wr_en[g_id]    = 1'b1;
            wr_state[g_id] = new_st;
            rsp_v_d[g_id]  = 1'b1;
            rsp_st_d       = new_st;
            rsp_peer_d     = 1'b1;
          end else begin
            busy_d      = 1'b1;
            pend_core_d = g_id;
            pend_addr_d = sel_addr;
            pend_wr_d   = (sel_type == RQ_WR);
            mem_v_d     = 1'b1;
          end
        end
        RQ_UPG: begin
          snp_v_d   = hit;
          snp_inv_d = 1'b1;
          for (int c = 0; c < N_CORES; c++)
            if (hit[c]) begin
              wr_en[c]    = 1'b1;
              wr_state[c] = ST_I;
            end
          if (self_part) begin
            wr_en[g_id]    = 1'b1;
            wr_state[g_id] = ST_M;
          end
          rsp_v_d[g_id] = 1'b1;
          rsp_st_d      = ST_M;
        end
        default: begin
          if (self_part) begin
            wr_en[g_id]    = 1'b1;
            wr_state[g_id] = ST_I;
          end
          rsp_v_d[g_id] = 1'b1;
          rsp_st_d      = ST_I;
        end
      endcase
    end
  end

  // registered outputs
  logic [ADDR_W-1:0] out_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q          <= 1'b0;
      pend_core_q     <= '0;
      pend_addr_q     <= '0;
      pend_wr_q       <= 1'b0;
      rsp_valid_o     <= '0;
      rsp_state_o     <= '0;
      rsp_peer_o      <= 1'b0;
      snp_valid_o     <= '0;
      snp_inv_o       <= 1'b0;
      xfer_valid_o    <= 1'b0;
      xfer_move_o     <= 1'b0;
      xfer_src_o      <= '0;
      xfer_dst_o      <= '0;
      mem_req_valid_o <= 1'b0;
      out_addr_q      <= '0;
    end else begin
      busy_q          <= busy_d;
      pend_core_q     <= pend_core_d;
      pend_addr_q     <= pend_addr_d;
      pend_wr_q       <= pend_wr_d;
      rsp_valid_o     <= rsp_v_d;
      rsp_state_o     <= rsp_st_d;
      rsp_peer_o      <= rsp_peer_d;
      snp_valid_o     <= snp_v_d;
      snp_inv_o       <= snp_inv_d;
      xfer_valid_o    <= xfer_v_d;
      xfer_move_o     <= xfer_mv_d;
      xfer_src_o      <= src_id;
      xfer_dst_o      <= lk_core;
      mem_req_valid_o <= mem_v_d;
      out_addr_q      <= lk_addr;
    end
  end

  assign snp_addr_o     = out_addr_q;
  assign xfer_addr_o    = out_addr_q;
  assign mem_req_addr_o = out_addr_q;
endmodule

// File: rtl/scu_checker.sv
module scu_checker #(
  parameter int N_CORES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CORES-1:0] participate_i,
  input logic [N_CORES-1:0] req_valid_i,
  input logic [N_CORES-1:0] req_ready_o,
  input logic [N_CORES-1:0] rsp_valid_o,
  input logic [N_CORES-1:0] snp_valid_o,
  input logic               snp_inv_o,
  input logic               xfer_valid_o,
  input logic               xfer_move_o,
  input logic               mem_req_valid_o
);
  a_r8_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  a_r8_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);

  a_r7_no_snoop_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_o & ~participate_i) == '0);

  a_r2_peer_not_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> !mem_req_valid_o);

  a_r4_move_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_move_o) |-> snp_inv_o);

  a_r5_single_mem_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o);

  a_r6_no_self_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_o & rsp_valid_o) == '0);

  a_r8_onehot_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
endmodule

bind snoop_ctl_unit scu_checker #(.N_CORES(N_CORES)) u_scu_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .participate_i   (participate_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .snp_valid_o     (snp_valid_o),
  .snp_inv_o       (snp_inv_o),
  .xfer_valid_o    (xfer_valid_o),
  .xfer_move_o     (xfer_move_o),
  .mem_req_valid_o (mem_req_valid_o)
);

// File: tb/snoop_ctl_unit_tb_top.sv
module snoop_ctl_unit_tb_top;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int CW = 2;

  localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, UPG = 2'd2, EV = 2'd3;
  localparam logic [AW-1:0] LA = 12'h3A5, LB = 12'h0C7, LC = 12'h0E1, LD = 12'h1F0;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    participate_i = 4'b0111;
  logic [N-1:0]    req_valid_i = '0;
  logic [2*N-1:0]  req_type_i = '0;
  logic [AW*N-1:0] req_addr_i = '0;
  logic [N-1:0]    req_ready_o, rsp_valid_o, snp_valid_o;
  logic [1:0]      rsp_state_o;
  logic            rsp_peer_o, snp_inv_o, xfer_valid_o, xfer_move_o, mem_req_valid_o;
  logic [AW-1:0]   snp_addr_o, xfer_addr_o, mem_req_addr_o;
  logic [CW-1:0]   xfer_src_o, xfer_dst_o;
  logic            mem_fill_valid_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  snoop_ctl_unit dut_i (
    .clk_i, .rst_ni, .participate_i, .req_valid_i, .req_type_i, .req_addr_i,
    .req_ready_o, .rsp_valid_o, .rsp_state_o, .rsp_peer_o, .snp_valid_o,
    .snp_inv_o, .snp_addr_o, .xfer_valid_o, .xfer_move_o, .xfer_src_o,
    .xfer_dst_o, .xfer_addr_o, .mem_req_valid_o, .mem_req_addr_o,
    .mem_fill_valid_i
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // drive a request, wait for grant, return at the negedge after the grant edge
  task automatic issue(input int c, input logic [1:0] t, input logic [AW-1:0] a);
    @(negedge clk_i);
    req_valid_i[c] = 1'b1;
    req_type_i[c*2 +: 2] = t;
    req_addr_i[c*AW +: AW] = a;
    #1;
    while (!req_ready_o[c]) begin
      @(negedge clk_i);
      #1;
    end
    @(posedge clk_i);
    #1 req_valid_i[c] = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic fill();
    mem_fill_valid_i = 1'b1;
    @(posedge clk_i);
    #1 mem_fill_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic expect_mem(input string rq, input logic [AW-1:0] a);
    chk(rq, "mem_req_valid", mem_req_valid_o, 1);
    chk(rq, "mem_req_addr", mem_req_addr_o, a);
    chk(rq, "xfer_valid", xfer_valid_o, 0);
    chk(rq, "rsp_valid", rsp_valid_o, 0);
    chk(rq, "snp_valid", snp_valid_o, 0);
  endtask

  task automatic expect_fill(input string rq, input int c, input logic [1:0] st);
    fill();
    chk(rq, "fill rsp_valid", rsp_valid_o, 32'(1 << c));
    chk(rq, "fill rsp_state", rsp_state_o, st);
    chk(rq, "fill rsp_peer", rsp_peer_o, 0);
    chk(rq, "fill snp_valid", snp_valid_o, 0);
  endtask

  task automatic expect_peer(input string rq, input int dst, input int src, input logic mv,
                             input logic [N-1:0] snp, input logic inv, input logic [1:0] st);
    chk(rq, "xfer_valid", xfer_valid_o, 1);
    chk(rq, "xfer_src", xfer_src_o, src);
    chk(rq, "xfer_dst", xfer_dst_o, dst);
    chk(rq, "xfer_move", xfer_move_o, mv);
    chk(rq, "xfer_addr", xfer_addr_o, LA);
    chk(rq, "snp_valid", snp_valid_o, snp);
    chk(rq, "snp_inv", snp_inv_o, inv);
    chk(rq, "rsp_valid", rsp_valid_o, 32'(1 << dst));
    chk(rq, "rsp_state", rsp_state_o, st);
    chk(rq, "rsp_peer", rsp_peer_o, 1);
    chk(rq, "mem_req_valid", mem_req_valid_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R10", "req_ready", req_ready_o, 0);
    chk("R10", "rsp_valid", rsp_valid_o, 0);
    chk("R10", "snp_valid", snp_valid_o, 0);
    chk("R10", "xfer_valid", xfer_valid_o, 0);
    chk("R10", "mem_req_valid", mem_req_valid_o, 0);
  endtask

  task automatic t_first_miss();
    issue(0, RD, LA);
    expect_mem("R5", LA);
    expect_fill("R5", 0, E);
  endtask

  task automatic t_clean_copy();
    issue(1, RD, LA);
    expect_peer("R3", 1, 0, 1'b0, 4'b0001, 1'b0, S);
  endtask

  task automatic t_lowest_src();
    issue(2, RD, LA);
    expect_peer("R11", 2, 0, 1'b0, 4'b0011, 1'b0, S);
  endtask

  task automatic t_upgrade();
    issue(1, UPG, LA);
    chk("R6", "snp_valid", snp_valid_o, 4'b0101);
    chk("R6", "snp_inv", snp_inv_o, 1);
    chk("R6", "rsp_valid", rsp_valid_o, 4'b0010);
    chk("R6", "rsp_state", rsp_state_o, M);
    chk("R6", "xfer_valid", xfer_valid_o, 0);
  endtask

  task automatic t_dirty_move();
    issue(2, RD, LA);
    expect_peer("R4", 2, 1, 1'b1, 4'b0010, 1'b1, M);
    issue(0, WR, LA);
    expect_peer("R4", 0, 2, 1'b1, 4'b0100, 1'b1, M);
  endtask

  task automatic t_evict();
    issue(0, EV, LA);
    chk("R1", "evict rsp_valid", rsp_valid_o, 4'b0001);
    chk("R1", "evict rsp_state", rsp_state_o, I);
    chk("R1", "evict snp_valid", snp_valid_o, 0);
    issue(1, RD, LA);
    expect_mem("R1", LA);
    expect_fill("R1", 1, E);
  endtask

  task automatic t_write_clean();
    issue(0, RD, LA);
    expect_peer("R3", 0, 1, 1'b0, 4'b0010, 1'b0, S);
    issue(2, WR, LA);
    expect_peer("R9", 2, 0, 1'b0, 4'b0011, 1'b1, M);
  endtask

  task automatic t_outsider();
    issue(3, RD, LA);
    expect_mem("R7", LA);
    expect_fill("R7", 3, E);
    issue(0, RD, LA);
    expect_peer("R7", 0, 2, 1'b1, 4'b0100, 1'b1, M);
  endtask

  task automatic t_write_mem();
    issue(1, WR, LB);
    expect_mem("R5", LB);
    expect_fill("R5", 1, M);
  endtask

  task automatic t_silent_upgrade();
    issue(0, RD, LC);
    expect_mem("R6", LC);
    expect_fill("R6", 0, E);
    issue(0, UPG, LC);
    chk("R6", "E upgrade snp_valid", snp_valid_o, 0);
    chk("R6", "E upgrade rsp_state", rsp_state_o, M);
    chk("R6", "E upgrade rsp_valid", rsp_valid_o, 4'b0001);
  endtask

  task automatic t_round_robin();
    int exp_order [4] = '{2, 0, 2, 0};
    @(negedge clk_i);
    req_type_i[0 +: 2] = EV;
    req_addr_i[0 +: AW] = LD;
    req_type_i[4 +: 2] = EV;
    req_addr_i[2*AW +: AW] = LD;
    req_valid_i = 4'b0101;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R8", "grant vector", req_ready_o, 32'(1 << exp_order[k]));
      @(negedge clk_i);
    end
    req_valid_i = '0;
    #1 chk("R8", "idle grant", req_ready_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_first_miss();
    t_clean_copy();
    t_lowest_src();
    t_upgrade();
    t_dirty_move();
    t_evict();
    t_write_clean();
    t_outsider();
    t_write_mem();
    t_silent_upgrade();
    t_round_robin();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule